// File: doc/BRIEF.md
# Double-Buffered Color Matrix Converter

This block applies a 3x4 affine color transform to a stream of three-channel pixels (RGB or YCbCr). Each output channel is a signed weighted sum of the three input channels plus a constant offset. The result is rounded to the nearest integer and clamped to the unsigned pixel range. A mode value of zero selects a pass-through path that leaves pixels unchanged.

Two coefficient banks hold two complete matrices. Software reads back the active mode, loads the matrix into the bank that is not in use, and then writes the matching mode code. The active mode changes only when the frame-start strobe arrives, so the pixels of one frame are never computed with two different matrices. Pixels enter and leave on valid/ready handshakes. The pipeline has a fixed depth of three stages and stalls as a whole when the output is held off.

Top module: `color_matrix_xform`

## Requirements
- R1: After reset the active and pending modes are 0 (pass-through), `out_valid` is low and `in_ready` is high. Both banks reset to the identity matrix: 0x2000 at indices 0, 5 and 10, and zero at every other index.
- R2: When `stat_idx` equals 9, `stat_data` shows the active mode. For every other index `stat_data` is 0.
- R3: In mode 0 each output channel equals the input channel of the same number, unchanged.
- R4: In mode 4 (bank A, `cfg_bank`=0) and mode 5 (bank B, `cfg_bank`=1), coefficient index i holds row i/4, column i%4, so index 0 is c11 and index 11 is c34. Each coefficient is signed 16-bit with 0x2000 meaning 1.0. The formula is out_r = floor((cr1*ch0 + cr2*ch1 + cr3*ch2 + cr4*2^DW + 4096) / 8192).
- R5: A result below 0 gives 0, and a result above 2^DW-1 gives 2^DW-1.
- R6: A mode write of 0, 4 or 5 sets the pending mode, and a write of any other value is ignored. The active mode takes the pending value only in a cycle where `frame_start` is high. If a mode write and `frame_start` fall in the same cycle, the written value becomes active.
- R7: A coefficient write to the bank used by the active mode is ignored. A write to the other bank takes effect.
- R8: With `out_ready` held high, a pixel accepted in cycle t appears on the outputs in cycle t+3, and one pixel is accepted per cycle.
- R9: While `out_valid` is high and `out_ready` is low, the outputs hold their values and `in_ready` is low.
- R10: A pixel is computed with the mode and coefficients that were active in the cycle it was accepted, even if `frame_start` switches the mode in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_bank | input | 1 | Target bank: 0 = A, 1 = B |
| cfg_idx | input | 4 | Coefficient index 0..11 |
| cfg_data | input | 16 | Signed 2.13 coefficient value |
| mode_we | input | 1 | Mode write strobe |
| mode_val | input | 3 | Requested mode: 0 pass-through, 4 bank A, 5 bank B |
| frame_start | input | 1 | Frame boundary strobe; applies the pending mode |
| stat_idx | input | 4 | Status index |
| stat_data | output | 3 | Active mode when `stat_idx` is 9, else 0 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_ch0 | input | 10 | Input channel 0 |
| in_ch1 | input | 10 | Input channel 1 |
| in_ch2 | input | 10 | Input channel 2 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take a pixel |
| out_ch0 | output | 10 | Output channel 0 |
| out_ch1 | output | 10 | Output channel 1 |
| out_ch2 | output | 10 | Output channel 2 |

## Verification
A bad active-mode register shows on `stat_data` in the same cycle. It also shows on the next pixel out, three cycles after that pixel is accepted, because the wrong matrix or the pass-through path is applied. A write that slips through into the live bank changes only the channel whose row it hit. The first pixel after the write exposes it, which is why a blocked write is followed at once by a pixel with a known result. Faults in the handshake or the stall logic show as a missing, moved or changed output while `out_ready` is low, within a few cycles.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int unsigned NROW  = 3;
  localparam int unsigned NCOL  = 4;
  localparam int unsigned NCOEF = NROW * NCOL;
  localparam int unsigned MW    = 3;
  localparam int unsigned SW    = 4;
  localparam logic [SW-1:0] STAT_MODE_IDX = 4'd9;

  typedef enum logic [MW-1:0] {
    CMX_BYPASS = 3'd0,
    CMX_BANK_A = 3'd4,
    CMX_BANK_B = 3'd5
  } cmx_mode_e;

  function automatic logic mode_is_legal(input logic [MW-1:0] m);
    return (m == CMX_BYPASS) || (m == CMX_BANK_A) || (m == CMX_BANK_B);
  endfunction
endpackage

// File: rtl/cmx_coef_banks.sv
module cmx_coef_banks
  import cmx_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_bank,
  input  logic [SW-1:0]        cfg_idx,
  input  logic [CW-1:0]        cfg_data,
  input  logic                 mode_we,
  input  logic [MW-1:0]        mode_val,
  input  logic                 frame_start,
  output cmx_mode_e            active_mode,
  output logic [1:0]           bank_wr_en,
  output logic signed [CW-1:0] sel_coef [NCOEF]
);
  localparam logic [CW-1:0] UNITY = CW'(1) << FRAC;

  logic signed [CW-1:0] bank_q [2][NCOEF];
  cmx_mode_e pend_q, pend_d, act_q;
  logic idx_ok;

  function automatic logic [CW-1:0] reset_coef(input int i);
    return (i % (NCOL + 1) == 0) ? UNITY : '0;
  endfunction

  assign idx_ok = cfg_idx < SW'(NCOEF);
  assign pend_d = (mode_we && mode_is_legal(mode_val)) ? cmx_mode_e'(mode_val) : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= CMX_BYPASS;
      act_q  <= CMX_BYPASS;
    end else begin
      pend_q <= pend_d;
      if (frame_start) act_q <= pend_d;
    end
  end

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      localparam cmx_mode_e OWN_MODE = (b == 0) ? CMX_BANK_A : CMX_BANK_B;
      assign bank_wr_en[b] = cfg_we && (cfg_bank == 1'(b)) && idx_ok && (act_q != OWN_MODE);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < int'(NCOEF); i++) bank_q[b][i] <= reset_coef(i);
        end else if (bank_wr_en[b]) begin
          bank_q[b][cfg_idx] <= cfg_data;
        end
      end
    end

    for (genvar i = 0; i < int'(NCOEF); i++) begin : g_sel
      assign sel_coef[i] = (act_q == CMX_BANK_B) ? bank_q[1][i] : bank_q[0][i];
    end
  endgenerate

  assign active_mode = act_q;
endmodule

// File: rtl/cmx_row.sv
module cmx_row #(
  parameter int unsigned DW   = 10,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 s1_byp,
  input  logic [DW-1:0]        s1_x0,
  input  logic [DW-1:0]        s1_x1,
  input  logic [DW-1:0]        s1_x2,
  input  logic [DW-1:0]        s1_self,
  input  logic signed [CW-1:0] k0,
  input  logic signed [CW-1:0] k1,
  input  logic signed [CW-1:0] k2,
  input  logic signed [CW-1:0] k3,
  output logic [DW-1:0]        y
);
  localparam int unsigned AW = CW + DW + 3;
  localparam logic signed [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} << (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW){1'b0}}, {DW{1'b1}}};

  function automatic logic signed [AW-1:0] mac_row(
    input logic [DW-1:0] a0, a1, a2,
    input logic signed [CW-1:0] w0, w1, w2, w3);
    logic signed [AW-1:0] sa0, sa1, sa2, sw0, sw1, sw2, sw3;
    sa0 = {{(AW-DW){1'b0}}, a0};
    sa1 = {{(AW-DW){1'b0}}, a1};
    sa2 = {{(AW-DW){1'b0}}, a2};
    sw0 = {{(AW-CW){w0[CW-1]}}, w0};
    sw1 = {{(AW-CW){w1[CW-1]}}, w1};
    sw2 = {{(AW-CW){w2[CW-1]}}, w2};
    sw3 = {{(AW-CW){w3[CW-1]}}, w3};
    return sw0 * sa0 + sw1 * sa1 + sw2 * sa2 + (sw3 <<< DW);
  endfunction

  function automatic logic [DW-1:0] round_sat(input logic signed [AW-1:0] acc);
    logic signed [AW-1:0] q;
    q = (acc + HALF) >>> FRAC;
    if (q < 0) return '0;
    if (q > MAXV) return '1;
    return q[DW-1:0];
  endfunction

  logic signed [AW-1:0] acc_q;
  logic                 byp_q;
  logic [DW-1:0]        pass_q, y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      byp_q  <= 1'b1;
      pass_q <= '0;
      y_q    <= '0;
    end else if (adv) begin
      acc_q  <= mac_row(s1_x0, s1_x1, s1_x2, k0, k1, k2, k3);
      byp_q  <= s1_byp;
      pass_q <= s1_self;
      y_q    <= byp_q ? pass_q : round_sat(acc_q);
    end
  end

  assign y = y_q;
endmodule

// File: rtl/color_matrix_xform.sv
module color_matrix_xform
  import cmx_pkg::*;
#(
  parameter int unsigned DW   = 10,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_bank,
  input  logic [SW-1:0] cfg_idx,
  input  logic [CW-1:0] cfg_data,
  input  logic          mode_we,
  input  logic [MW-1:0] mode_val,
  input  logic          frame_start,
  input  logic [SW-1:0] stat_idx,
  output logic [MW-1:0] stat_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_ch0,
  input  logic [DW-1:0] in_ch1,
  input  logic [DW-1:0] in_ch2,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_ch0,
  output logic [DW-1:0] out_ch1,
  output logic [DW-1:0] out_ch2
);
  cmx_mode_e            active_mode;
  logic [1:0]           bank_wr_en;
  logic signed [CW-1:0] sel_coef [NCOEF];

  logic                 adv, s1_v, s2_v, s3_v, s1_byp;
  logic [DW-1:0]        s1_px [NROW];
  logic signed [CW-1:0] s1_coef [NCOEF];
  logic [DW-1:0]        row_y [NROW];

  cmx_coef_banks #(.CW(CW), .FRAC(FRAC)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .mode_we(mode_we), .mode_val(mode_val), .frame_start(frame_start),
    .active_mode(active_mode), .bank_wr_en(bank_wr_en), .sel_coef(sel_coef)
  );

  assign adv       = !s3_v || out_ready;
  assign in_ready  = adv;
  assign out_valid = s3_v;
  assign stat_data = (stat_idx == STAT_MODE_IDX) ? active_mode : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_byp <= 1'b1;
      for (int r = 0; r < int'(NROW); r++) s1_px[r] <= '0;
      for (int i = 0; i < int'(NCOEF); i++) s1_coef[i] <= '0;
    end else if (adv && in_valid) begin
      s1_byp   <= (active_mode == CMX_BYPASS);
      s1_px[0] <= in_ch0;
      s1_px[1] <= in_ch1;
      s1_px[2] <= in_ch2;
      for (int i = 0; i < int'(NCOEF); i++) s1_coef[i] <= sel_coef[i];
    end
  end

  generate
    for (genvar r = 0; r < int'(NROW); r++) begin : g_row
      cmx_row #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(adv), .s1_byp(s1_byp),
        .s1_x0(s1_px[0]), .s1_x1(s1_px[1]), .s1_x2(s1_px[2]), .s1_self(s1_px[r]),
        .k0(s1_coef[NCOL*r]), .k1(s1_coef[NCOL*r+1]),
        .k2(s1_coef[NCOL*r+2]), .k3(s1_coef[NCOL*r+3]),
        .y(row_y[r])
      );
    end
  endgenerate

  assign out_ch0 = row_y[0];
  assign out_ch1 = row_y[1];
  assign out_ch2 = row_y[2];
endmodule

// File: rtl/cmx_checker.sv
module cmx_checker #(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_ch0,
  input logic [DW-1:0] out_ch1,
  input logic [DW-1:0] out_ch2,
  input logic          frame_start,
  input logic [2:0]    active_mode,
  input logic [1:0]    bank_wr_en
);
  logic [2:0] acc_h, rdy_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_h <= '0;
      rdy_h <= '0;
    end else begin
      acc_h <= {acc_h[1:0], in_valid && in_ready};
      rdy_h <= {rdy_h[1:0], out_ready};
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_h[2] && rdy_h[1] && rdy_h[0]) |-> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ch0) && $stable(out_ch1) && $stable(out_ch2)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_mode_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_mode));

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 3'd0) || (active_mode == 3'd4) || (active_mode == 3'd5));

  p_guard_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en[0] |-> (active_mode != 3'd4));

  p_guard_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en[1] |-> (active_mode != 3'd5));

  p_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr_en));
endmodule

bind color_matrix_xform cmx_checker #(.DW(DW)) u_cmx_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_ch0(out_ch0), .out_ch1(out_ch1), .out_ch2(out_ch2),
  .frame_start(frame_start), .active_mode(active_mode), .bank_wr_en(bank_wr_en)
);

// File: tb/test_color_matrix_xform.sv
module test_color_matrix_xform;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_bank = 0, mode_we = 0, frame_start = 0;
  logic [3:0] cfg_idx = 0, stat_idx = 4'd9;
  logic [15:0] cfg_data = 0;
  logic [2:0] mode_val = 0, stat_data;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [9:0] in_ch0 = 0, in_ch1 = 0, in_ch2 = 0, out_ch0, out_ch1, out_ch2;
  int checks = 0, fails = 0;
  logic [15:0] kb [12];

  always #4 clk = ~clk;

  color_matrix_xform i_color_matrix_xform (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input int r, input longint a0, a1, a2);
    longint n, m;
    n = longint'($signed(kb[4*r])) * a0 + longint'($signed(kb[4*r+1])) * a1
      + longint'($signed(kb[4*r+2])) * a2 + longint'($signed(kb[4*r+3])) * 1024 + 4096;
    m = (n - (((n % 8192) + 8192) % 8192)) / 8192;
    if (m < 0) m = 0;
    if (m > 1023) m = 1023;
    return m;
  endfunction

  task automatic wr_coef(input logic b, input int idx, input logic [15:0] v);
    @(negedge clk); cfg_we = 1; cfg_bank = b; cfg_idx = 4'(idx); cfg_data = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode_we = 1; mode_val = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic push(input string tag, input int a0, a1, a2, e0, e1, e2, input bit fs = 0);
    @(negedge clk); in_valid = 1; in_ch0 = 10'(a0); in_ch1 = 10'(a1); in_ch2 = 10'(a2);
    frame_start = fs;
    @(negedge clk); in_valid = 0; frame_start = 0;
    @(negedge clk); chk({tag, " early"}, out_valid, 0);
    @(negedge clk);
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " ch0"}, out_ch0, e0);
    chk({tag, " ch1"}, out_ch1, e1);
    chk({tag, " ch2"}, out_ch2, e2);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 R2 mode", stat_data, 0);
  endtask

  task automatic t_bypass();
    push("R3 bypass a", 1023, 0, 555, 1023, 0, 555);
    push("R3 bypass b", 1, 512, 77, 1, 512, 77);
  endtask

  task automatic t_pending_and_identity();
    set_mode(3'd4);
    chk("R6 not yet active", stat_data, 0);
    push("R6 still bypass", 9, 8, 7, 9, 8, 7);
    frame();
    chk("R6 R2 active A", stat_data, 4);
    push("R1 R4 identity A", 600, 33, 1000, 600, 33, 1000);
  endtask

  task automatic t_load_b();
    kb = '{16'h2cdd, 16'h2000, 16'h0000, 16'he991,
           16'h1000, 16'h1000, 16'h0000, 16'h0000,
           16'h0000, 16'h0000, 16'h2000, 16'h0400};
    for (int i = 0; i < 12; i++) wr_coef(1'b1, i, kb[i]);
    set_mode(3'd5);
    frame();
    chk("R2 active B", stat_data, 5);
    push("R4 bt601 row", 512, 512, 300, 512, 512, 428);
    push("R4 mixed", 700, 100, 50, int'(model(0, 700, 100, 50)),
         int'(model(1, 700, 100, 50)), int'(model(2, 700, 100, 50)));
    push("R5 clamp high", 1023, 1023, 1000, 1023, 1023, 1023);
    push("R5 clamp low", 0, 0, 5, 0, 0, 133);
  endtask

  task automatic t_guard();
    wr_coef(1'b1, 0, 16'h0000);
    push("R7 live bank kept", 700, 100, 50, int'(model(0, 700, 100, 50)),
         int'(model(1, 700, 100, 50)), int'(model(2, 700, 100, 50)));
    wr_coef(1'b0, 0, 16'h1000);
  endtask

  task automatic t_modes();
    set_mode(3'd3);
    frame();
    chk("R6 illegal ignored", stat_data, 5);
    @(negedge clk); stat_idx = 4'd8; #1 chk("R2 other index", stat_data, 0);
    stat_idx = 4'd9;
    @(negedge clk); mode_we = 1; mode_val = 3'd0; frame_start = 1;
    @(negedge clk); mode_we = 0; frame_start = 0;
    chk("R6 same cycle", stat_data, 0);
  endtask

  task automatic t_boundary();
    set_mode(3'd5); frame();
    set_mode(3'd0);
    push("R10 old matrix", 700, 100, 50, int'(model(0, 700, 100, 50)),
         int'(model(1, 700, 100, 50)), int'(model(2, 700, 100, 50)), 1'b1);
    chk("R10 switched", stat_data, 0);
    push("R10 new bypass", 700, 100, 50, 700, 100, 50);
    set_mode(3'd4); frame();
    push("R7 idle write took", 600, 10, 20, 300, 10, 20);
  endtask

  task automatic t_backpressure();
    @(negedge clk); out_ready = 0; in_valid = 1; in_ch0 = 10'd600; in_ch1 = 10'd10; in_ch2 = 10'd20;
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);
    chk("R9 held valid", out_valid, 1);
    chk("R9 in_ready low", in_ready, 0);
    chk("R9 held ch0", out_ch0, 300);
    @(negedge clk);
    chk("R9 still ch2", out_ch2, 20);
    out_ready = 1;
    @(negedge clk);
    chk("R9 drained", out_valid, 0);
  endtask

  task automatic t_stream();
    set_mode(3'd0); frame();
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk("R8 stream valid", out_valid, 1);
        chk("R8 stream data", out_ch1, 100 + i - 3);
      end
      in_valid = (i < 4);
      in_ch0 = 10'(i); in_ch1 = 10'(100 + i); in_ch2 = 10'(200 + i);
    end
    in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_bypass();
    t_pending_and_identity();
    t_load_b();
    t_guard();
    t_modes();
    t_boundary();
    t_backpressure();
    t_stream();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule